// File: doc/BRIEF.md
# Packed-Pixel Plot Merge Unit

This unit writes one pixel into a frame buffer in which several pixels share each byte. It leaves every other pixel in that byte as it was. The caller supplies the byte address, the index of the pixel within the byte, a colour index, a depth select and a plot operation. The unit builds a bit mask and a positioned colour pattern for that depth, then reads the byte, merges the new pixel in, and writes the byte back. It pulses done when the write is finished.

The bits of one pixel at 2 and 4 bits per pixel are not adjacent. At 2 bpp the most significant colour bit lies in the upper nibble and the least significant colour bit lies in the lower nibble. At 4 bpp the two pixels take alternate bits. Mask and data generation follow this interleaving. The memory side is a plain synchronous byte port with a read latency of one cycle.

The caller computes the address and decides which byte to touch. Clipping and line drawing are also left to the caller.

Top module: `pxplot_merge`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, req_ready is 1 and mem_rd_en, mem_wr_en, done and err are all 0.
- R2: With req_depth = 0 (1 bpp), pixel n (0 to 7, 0 leftmost) occupies bit 7−n, and colour bit 0 is the value written there.
- R3: With req_depth = 1 (2 bpp), pixel n (0 to 3) occupies the mask 0x88>>n. Colour bit 1 goes to the bit in 0x80>>n and colour bit 0 goes to the bit in 0x08>>n.
- R4: With req_depth = 2 (4 bpp), pixel 0 occupies the odd bits (0xAA) with colour bit k at bit 2k+1. Pixel 1 occupies the even bits (0x55) with colour bit k at bit 2k.
- R5: req_op selects the merge:
  - 0 is store: the pixel takes the colour.
  - 1 is OR.
  - 2 is AND.
  - 3 is XOR with the colour.
  - 4 is invert: the pixel bits are complemented.
  Under every operation, bits outside the pixel mask are written back unchanged.
- R6: Colour bits above the selected depth have no effect on the written byte.
- R7: A request is accepted on a clock edge where req_valid and req_ready are both 1. The byte address is taken from req_addr at acceptance. The sequence then runs:
  - mem_rd_en is high for one cycle, starting the cycle after acceptance.
  - mem_wr_en is high for one cycle, two cycles after the read.
  - done is high the cycle after the write, which is the fourth cycle after acceptance.
  - The accepted address stays on mem_addr throughout.
- R8: While a plot is in progress req_ready is 0, and req_valid is ignored: no second read or write takes place and no other byte changes.
- R9: A request is rejected when any of the following holds:
  - the pixel index is out of range for its depth (n > 3 at 2 bpp, n > 1 at 4 bpp);
  - req_depth is 3;
  - req_op is 5, 6 or 7.
  A rejected request performs neither a read nor a write, and raises done and err together in the cycle after acceptance.
- R10: done is a single-cycle pulse, err is never high without done, and req_ready returns to 1 the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Plot request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_addr | input | ADDR_W | Byte address to modify |
| req_pix | input | 3 | Pixel index within the byte, 0 = leftmost |
| req_colour | input | 4 | Colour index, low bits used per depth |
| req_depth | input | 2 | 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp, 3 reserved |
| req_op | input | 3 | 0 store, 1 OR, 2 AND, 3 XOR, 4 invert |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Merged byte to write |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd_en |
| done | output | 1 | Plot finished (one cycle) |
| err | output | 1 | Request rejected, valid with done |

## Verification
The hardest situation to reach is a new request that arrives while a plot is still in flight. Because req_valid is only sampled while idle, such a request must leave no trace at all. The bench starts a plot, then holds a second request with a different address on the inputs through the read, latency and write cycles. It releases the second request before the unit returns to idle. It then confirms three things: the second byte is untouched, and exactly one read and one write were issued. Rejected requests are also driven, for each reason separately: out-of-range pixel indices at both multi-bit depths, the reserved depth and the reserved operations. In each case the bench checks that neither memory strobe moves.

// File: rtl/pxplot_pkg.sv
package pxplot_pkg;

   localparam int unsigned PX_BYTE_W   = 8;
   localparam int unsigned PX_COLOUR_W = 4;
   localparam int unsigned PX_INDEX_W  = 3;

   typedef enum logic [1:0] {
      DEPTH_1BPP = 2'd0,
      DEPTH_2BPP = 2'd1,
      DEPTH_4BPP = 2'd2,
      DEPTH_RSVD = 2'd3
   } px_depth_e;

   typedef enum logic [2:0] {
      OP_STORE  = 3'd0,
      OP_OR     = 3'd1,
      OP_AND    = 3'd2,
      OP_XOR    = 3'd3,
      OP_INVERT = 3'd4
   } px_op_e;

   localparam logic [2:0] OP_LAST = 3'd4;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD   = 3'd1,
      ST_LAT  = 3'd2,
      ST_WR   = 3'd3,
      ST_FIN  = 3'd4
   } px_state_e;

endpackage

// File: rtl/pxplot_layout.sv
// Mask and positioned-colour generation for one pixel in a packed byte.
module pxplot_layout
   import pxplot_pkg::*;
#(
   parameter int unsigned BYTE_W   = PX_BYTE_W,
   parameter int unsigned COLOUR_W = PX_COLOUR_W,
   parameter int unsigned INDEX_W  = PX_INDEX_W
) (
   input  logic [INDEX_W-1:0]  pix,
   input  logic [COLOUR_W-1:0] colour,
   input  logic [1:0]          depth,
   output logic [BYTE_W-1:0]   mask,
   output logic [BYTE_W-1:0]   data,
   output logic                in_range
);

   localparam int unsigned HALF_W   = BYTE_W / 2;
   localparam int unsigned PIX_1BPP = BYTE_W;
   localparam int unsigned PIX_2BPP = BYTE_W / 2;
   localparam int unsigned PIX_4BPP = BYTE_W / 4;

   // Elaboration checks: the interleaved layouts are defined for bytes only.
   if (BYTE_W != 8) begin : g_bad_byte
      $error("pxplot_layout: BYTE_W must be 8");
   end
   if (COLOUR_W != 4) begin : g_bad_colour
      $error("pxplot_layout: COLOUR_W must be 4");
   end
   if ((1 << INDEX_W) < PIX_1BPP) begin : g_bad_index
      $error("pxplot_layout: INDEX_W too narrow");
   end

   // 4 bpp interleave: colour bit k lands on odd bit 2k+1 (left pixel).
   logic [BYTE_W-1:0] odd_spread;
   logic [BYTE_W-1:0] odd_lanes;
   for (genvar k = 0; k < COLOUR_W; k++) begin : g_spread
      assign odd_spread[2*k+1] = colour[k];
      assign odd_spread[2*k]   = 1'b0;
      assign odd_lanes[2*k+1]  = 1'b1;
      assign odd_lanes[2*k]    = 1'b0;
   end

   // 2 bpp: msb lane sits in the upper nibble, lsb lane in the lower nibble.
   logic [BYTE_W-1:0] pair_mask0;
   logic [BYTE_W-1:0] pair_data0;
   always_comb begin
      pair_mask0                 = '0;
      pair_data0                 = '0;
      pair_mask0[BYTE_W-1]       = 1'b1;
      pair_mask0[HALF_W-1]       = 1'b1;
      pair_data0[BYTE_W-1]       = colour[1];
      pair_data0[HALF_W-1]       = colour[0];
   end

   logic [BYTE_W-1:0] left_bit;
   assign left_bit = {1'b1, {(BYTE_W-1){1'b0}}};

   always_comb begin
      mask     = '0;
      data     = '0;
      in_range = 1'b0;
      unique case (px_depth_e'(depth))
         DEPTH_1BPP: begin
            in_range = (32'(pix) < PIX_1BPP);
            mask     = left_bit >> pix;
            data     = colour[0] ? mask : '0;
         end
         DEPTH_2BPP: begin
            in_range = (32'(pix) < PIX_2BPP);
            mask     = pair_mask0 >> pix[1:0];
            data     = pair_data0 >> pix[1:0];
         end
         DEPTH_4BPP: begin
            in_range = (32'(pix) < PIX_4BPP);
            mask     = odd_lanes  >> pix[0];
            data     = odd_spread >> pix[0];
         end
         default: begin
            in_range = 1'b0;
         end
      endcase
      if (!in_range) begin
         mask = '0;
         data = '0;
      end
   end

endmodule

// File: rtl/pxplot_combine.sv
// Bitwise merge of the positioned colour into the old byte under the mask.
module pxplot_combine
   import pxplot_pkg::*;
#(
   parameter int unsigned BYTE_W = PX_BYTE_W
) (
   input  logic [BYTE_W-1:0] old_byte,
   input  logic [BYTE_W-1:0] mask,
   input  logic [BYTE_W-1:0] data,
   input  logic [2:0]        op,
   output logic [BYTE_W-1:0] new_byte
);

   for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
      logic merged;
      always_comb begin
         unique case (px_op_e'(op))
            OP_STORE:  merged = data[b];
            OP_OR:     merged = old_byte[b] | data[b];
            OP_AND:    merged = old_byte[b] & data[b];
            OP_XOR:    merged = old_byte[b] ^ data[b];
            OP_INVERT: merged = ~old_byte[b];
            default:   merged = old_byte[b];
         endcase
      end
      assign new_byte[b] = mask[b] ? merged : old_byte[b];
   end

endmodule

// File: rtl/pxplot_ctrl.sv
// Read-modify-write sequencer.
module pxplot_ctrl
   import pxplot_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic bad,
   output logic ready,
   output logic rd_en,
   output logic lat_phase,
   output logic wr_en,
   output logic done,
   output logic err
);

   px_state_e state_q, state_d;
   logic      err_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start) state_d = bad ? ST_FIN : ST_RD;
         ST_RD:   state_d = ST_LAT;
         ST_LAT:  state_d = ST_WR;
         ST_WR:   state_d = ST_FIN;
         ST_FIN:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start) err_q <= bad;
      end
   end

   assign ready     = (state_q == ST_IDLE);
   assign rd_en     = (state_q == ST_RD);
   assign lat_phase = (state_q == ST_LAT);
   assign wr_en     = (state_q == ST_WR);
   assign done      = (state_q == ST_FIN);
   assign err       = (state_q == ST_FIN) && err_q;

   p_rd_to_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> ##2 wr_en);
   p_wr_to_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (done && !err));
   p_bad_skips_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && bad) |=> (done && err && !rd_en && !wr_en));
   p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && ready));
   p_busy_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !ready);

endmodule

// File: rtl/pxplot_merge.sv
// Packed-pixel plot merge unit: top level.
module pxplot_merge
   import pxplot_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter bit          REG_WDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_pix,
   input  logic [3:0]        req_colour,
   input  logic [1:0]        req_depth,
   input  logic [2:0]        req_op,
   output logic              mem_rd_en,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              done,
   output logic              err
);

   localparam int unsigned BYTE_W = PX_BYTE_W;

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("pxplot_merge: ADDR_W out of range 1..32");
   end

   logic [BYTE_W-1:0] lay_mask, lay_data;
   logic              lay_ok;
   logic              accept, bad_req, lat_phase;

   pxplot_layout #(
      .BYTE_W   (BYTE_W),
      .COLOUR_W (PX_COLOUR_W),
      .INDEX_W  (PX_INDEX_W)
   ) u_layout (
      .pix      (req_pix),
      .colour   (req_colour),
      .depth    (req_depth),
      .mask     (lay_mask),
      .data     (lay_data),
      .in_range (lay_ok)
   );

   assign accept  = req_valid && req_ready;
   assign bad_req = !lay_ok || (req_op > OP_LAST);

   pxplot_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .bad       (bad_req),
      .ready     (req_ready),
      .rd_en     (mem_rd_en),
      .lat_phase (lat_phase),
      .wr_en     (mem_wr_en),
      .done      (done),
      .err       (err)
   );

   // Request capture
   logic [ADDR_W-1:0] addr_q;
   logic [BYTE_W-1:0] mask_q, data_q;
   logic [2:0]        op_q;
   logic [1:0]        depth_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         mask_q  <= '0;
         data_q  <= '0;
         op_q    <= '0;
         depth_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         mask_q  <= lay_mask;
         data_q  <= lay_data;
         op_q    <= req_op;
         depth_q <= req_depth;
      end
   end

   assign mem_addr = addr_q;

   // Merge source and result; the variant picks where the register sits.
   logic [BYTE_W-1:0] merge_src, merge_out;

   pxplot_combine #(.BYTE_W(BYTE_W)) u_combine (
      .old_byte (merge_src),
      .mask     (mask_q),
      .data     (data_q),
      .op       (op_q),
      .new_byte (merge_out)
   );

   if (REG_WDATA) begin : g_reg_wdata
      logic [BYTE_W-1:0] wdata_q;
      assign merge_src = mem_rdata;
      always_ff @(posedge clk) begin
         if (!rst_n)         wdata_q <= '0;
         else if (lat_phase) wdata_q <= merge_out;
      end
      assign mem_wdata = wdata_q;
   end else begin : g_reg_rdata
      logic [BYTE_W-1:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n)         rdata_q <= '0;
         else if (lat_phase) rdata_q <= mem_rdata;
      end
      assign merge_src = rdata_q;
      assign mem_wdata = merge_out;
   end

   // Assertions
   p_mask_1bpp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && depth_q == DEPTH_1BPP) |-> ($countones(mask_q) == 1));
   p_mask_2bpp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && depth_q == DEPTH_2BPP) |-> ($countones(mask_q) == 2 &&
                                               $countones(mask_q[7:4]) == 1));
   p_mask_4bpp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && depth_q == DEPTH_4BPP) |-> (mask_q == 8'hAA || mask_q == 8'h55));
   p_outside_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((merge_out ^ merge_src) & ~mask_q) == '0);
   p_data_in_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> ((data_q & ~mask_q) == '0));
   p_addr_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> ##1 (mem_wr_en && $stable(mem_addr)));
   p_no_dual_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en) && !(req_ready && (mem_rd_en || mem_wr_en)));

endmodule

// File: tb/pxplot_merge_tb.sv
module pxplot_merge_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid;
   logic              req_ready;
   logic [ADDR_W-1:0] req_addr;
   logic [2:0]        req_pix;
   logic [3:0]        req_colour;
   logic [1:0]        req_depth;
   logic [2:0]        req_op;
   logic              mem_rd_en, mem_wr_en;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0]        mem_wdata;
   logic [7:0]        mem_rdata;
   logic              done, err;

   always #(CLK_PERIOD/2) clk = ~clk;

   pxplot_merge #(.ADDR_W(ADDR_W)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_addr   (req_addr),
      .req_pix    (req_pix),
      .req_colour (req_colour),
      .req_depth  (req_depth),
      .req_op     (req_op),
      .mem_rd_en  (mem_rd_en),
      .mem_wr_en  (mem_wr_en),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .done       (done),
      .err        (err)
   );

   // Byte memory model with a bench preload port
   logic [7:0] mem [0:255];
   logic       pk_en;
   logic [7:0] pk_addr, pk_data;
   int         rd_cnt, wr_cnt;
   logic [7:0] last_wr_addr;

   always @(posedge clk) begin
      if (pk_en) mem[pk_addr] <= pk_data;
      if (mem_rd_en) begin
         mem_rdata <= mem[mem_addr[7:0]];
         rd_cnt    <= rd_cnt + 1;
      end
      if (mem_wr_en) begin
         mem[mem_addr[7:0]] <= mem_wdata;
         wr_cnt             <= wr_cnt + 1;
         last_wr_addr       <= mem_addr[7:0];
      end
   end

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic poke(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      pk_en = 1'b1; pk_addr = a; pk_data = d;
      @(negedge clk);
      pk_en = 1'b0;
   endtask

   // Issue one plot, return latency (negedges to done), err, read/write counts
   task automatic plot(input logic [7:0] a, input logic [2:0] pix, input logic [3:0] col,
                       input logic [1:0] dep, input logic [2:0] op,
                       output int lat, output int e, output int rds, output int wrs);
      int r0, w0;
      @(negedge clk);
      r0 = rd_cnt; w0 = wr_cnt;
      req_addr = {8'h00, a}; req_pix = pix; req_colour = col;
      req_depth = dep; req_op = op; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!done && lat < 12) begin
         @(negedge clk);
         lat++;
      end
      e = err;
      @(posedge clk);
      rds = rd_cnt - r0; wrs = wr_cnt - w0;
   endtask

   typedef struct packed {
      logic [2:0] pix;
      logic [3:0] col;
      logic [1:0] dep;
      logic [2:0] op;
      logic [7:0] init;
      logic [7:0] expv;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [0:NV-1] = '{
      '{3'd0, 4'h1, 2'd0, 3'd0, 8'h00, 8'h80},  // R2 1bpp left
      '{3'd7, 4'h0, 2'd0, 3'd0, 8'hFF, 8'hFE},  // R2 1bpp right
      '{3'd3, 4'hE, 2'd0, 3'd0, 8'hFF, 8'hEF},  // R6 upper colour bits ignored
      '{3'd0, 4'h3, 2'd1, 3'd0, 8'h00, 8'h88},  // R3
      '{3'd1, 4'h2, 2'd1, 3'd0, 8'hFF, 8'hFB},  // R3 msb only
      '{3'd3, 4'h1, 2'd1, 3'd0, 8'h00, 8'h01},  // R3 lsb only
      '{3'd2, 4'hD, 2'd1, 3'd0, 8'h00, 8'h02},  // R6 2bpp
      '{3'd0, 4'hF, 2'd2, 3'd0, 8'h00, 8'hAA},  // R4 left
      '{3'd1, 4'h6, 2'd2, 3'd0, 8'hFF, 8'hBE},  // R4 right
      '{3'd0, 4'h9, 2'd2, 3'd0, 8'h00, 8'h82},  // R4 left spread
      '{3'd1, 4'h3, 2'd1, 3'd1, 8'h11, 8'h55},  // R5 or
      '{3'd0, 4'h2, 2'd1, 3'd2, 8'hFF, 8'hF7},  // R5 and
      '{3'd5, 4'h1, 2'd0, 3'd3, 8'hA5, 8'hA1},  // R5 xor
      '{3'd1, 4'h0, 2'd2, 3'd4, 8'h0F, 8'h5A},  // R5 invert
      '{3'd2, 4'h0, 2'd0, 3'd1, 8'h3C, 8'h3C},  // R5 or with zero
      '{3'd0, 4'h5, 2'd2, 3'd2, 8'hFF, 8'h77}   // R5 and 4bpp
   };

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int lat, e, rds, wrs;
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_pix = '0;
      req_colour = '0; req_depth = '0; req_op = '0;
      pk_en = 1'b0; pk_addr = '0; pk_data = '0;
      rd_cnt = 0; wr_cnt = 0; mem_rdata = '0; last_wr_addr = '0;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;

      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "ready in reset", int'(req_ready), 1);
      check("R1", "strobes/done/err in reset",
            int'({mem_rd_en, mem_wr_en, done, err}), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R1", "idle after reset", int'({req_ready, mem_rd_en, mem_wr_en, done, err}), 5'b10000);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         logic [7:0] a;
         a = 8'h10 + 8'(i);
         poke(a, VEC[i].init);
         plot(a, VEC[i].pix, VEC[i].col, VEC[i].dep, VEC[i].op, lat, e, rds, wrs);
         check("R2-R6 vec", $sformatf("byte v%0d", i), int'(mem[a]), int'(VEC[i].expv));
         check("R7", $sformatf("latency v%0d", i), lat, 4);
         check("R7", $sformatf("rd/wr/err v%0d", i), rds*100 + wrs*10 + e, 110);
         check("R7", $sformatf("write addr v%0d", i), int'(last_wr_addr), int'(a));
      end

      // R10: done one cycle, ready back
      poke(8'h60, 8'h00);
      plot(8'h60, 3'd4, 4'h1, 2'd0, 3'd0, lat, e, rds, wrs);
      check("R2", "1bpp pixel 4 -> bit 3", int'(mem[8'h60]), 8'h08);
      @(negedge clk);
      check("R10", "done low and ready after pulse", int'({done, err, req_ready}), 3'b001);

      // R8: request held while busy is ignored
      poke(8'h40, 8'h00);
      poke(8'h41, 8'h33);
      begin
         int r0, w0, busy_ready;
         @(negedge clk);
         r0 = rd_cnt; w0 = wr_cnt;
         req_addr = 16'h0040; req_pix = 3'd0; req_colour = 4'h1;
         req_depth = 2'd0; req_op = 3'd0; req_valid = 1'b1;
         @(negedge clk);
         req_addr = 16'h0041; req_op = 3'd4; req_pix = 3'd1;
         busy_ready = req_ready;
         @(negedge clk);
         busy_ready |= req_ready;
         @(negedge clk);
         busy_ready |= req_ready;
         req_valid = 1'b0;
         lat = 0;
         while (!done && lat < 12) begin @(negedge clk); lat++; end
         @(negedge clk);
         repeat (4) @(negedge clk);
         check("R8", "ready low while busy", busy_ready, 0);
         check("R8", "held request byte untouched", int'(mem[8'h41]), 8'h33);
         check("R8", "single rd and wr", (rd_cnt - r0)*10 + (wr_cnt - w0), 11);
         check("R8", "first byte written", int'(mem[8'h40]), 8'h80);
      end

      // R9: rejected requests
      poke(8'h50, 8'h3C);
      plot(8'h50, 3'd4, 4'h3, 2'd1, 3'd0, lat, e, rds, wrs);
      check("R9", "2bpp pix 4 err/lat/rd/wr", e*1000 + lat*100 + rds*10 + wrs, 1100);
      plot(8'h50, 3'd2, 4'hF, 2'd2, 3'd0, lat, e, rds, wrs);
      check("R9", "4bpp pix 2 err/lat/rd/wr", e*1000 + lat*100 + rds*10 + wrs, 1100);
      plot(8'h50, 3'd0, 4'h1, 2'd3, 3'd0, lat, e, rds, wrs);
      check("R9", "depth 3 err/lat/rd/wr", e*1000 + lat*100 + rds*10 + wrs, 1100);
      plot(8'h50, 3'd0, 4'h1, 2'd0, 3'd5, lat, e, rds, wrs);
      check("R9", "op 5 err/lat/rd/wr", e*1000 + lat*100 + rds*10 + wrs, 1100);
      check("R9", "byte unchanged after rejects", int'(mem[8'h50]), 8'h3C);
      @(negedge clk);
      check("R10", "err cleared after reject", int'({done, err, req_ready}), 3'b001);

      // R6 on 1bpp with colour 0x1 vs 0xF giving the same byte
      poke(8'h70, 8'h00);
      plot(8'h70, 3'd6, 4'hF, 2'd0, 3'd0, lat, e, rds, wrs);
      check("R6", "1bpp colour 0xF acts as 1", int'(mem[8'h70]), 8'h02);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule